// File: doc/BRIEF.md
# No-Load Creep Suppression Gate

This block sits in the sample stream between a magnitude source and the energy accumulators of a metering datapath. Each accepted sample carries two unsigned magnitudes: an apparent-power value and an RMS-current value. A source-select bit picks which of the two is forwarded. Selecting RMS current lets the accumulators count ampere-hours when no line voltage is present. The selected magnitude is compared against a creep threshold, and a sample under that threshold is forwarded as zero so that no energy is accumulated from noise at idle.

The threshold comes from a 2-bit code. Code 0 turns detection off. Codes 1, 2 and 3 pick successively finer fractions of a parameterised full-scale value. Each threshold is computed at elaboration and rounded down to an integer.

Whenever a sample is suppressed, a sticky no-load flag is set. The flag is cleared by a one-cycle clear strobe. It drives an interrupt line when its enable is on.

Both data interfaces use valid/ready. An input sample is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the single output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its data and no new sample is taken. The source select and the threshold code are sampled together with the data.

Top module: `nl_creep_gate`

## Requirements
- R1: With threshold code 0, every accepted sample is forwarded unchanged, including zero, and the no-load flag is never set.
- R2: Code 1 uses threshold floor(FULL_SCALE*3/10000), code 2 uses floor(FULL_SCALE*3/20000) and code 3 uses floor(FULL_SCALE*3/40000). A selected magnitude strictly below the active threshold is forwarded as zero. A magnitude equal to or above the threshold is forwarded unchanged.
- R3: Every accepted sample, suppressed or not, appears with `out_valid` high in the cycle after acceptance, so downstream sample timing is kept.
- R4: `src_irms`=0 selects `in_va` and `src_irms`=1 selects `in_irms`. The same thresholds apply to both sources, and the unselected input has no effect on the output.
- R5: An accepted sample suppressed under R2 sets `noload_flag`, which is visible in the cycle after acceptance. The flag stays set through later samples that are above the threshold.
- R6: A `noload_clr` pulse clears the flag in the next cycle. If a suppressed sample is accepted in the same cycle as the clear, the flag stays set.
- R7: `noload_irq` is high exactly when `noload_flag` and `noload_en` are both high.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_data` and `out_valid` hold. When `out_ready` rises, a waiting input is accepted on the same edge that drains the output.
- R9: After reset, `out_valid`, `noload_flag` and `noload_irq` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Gate can take a sample |
| in_va | input | DATA_W | Apparent-power magnitude |
| in_irms | input | DATA_W | RMS-current magnitude |
| src_irms | input | 1 | 1 selects RMS current, 0 apparent power |
| thr_mode | input | 2 | Threshold code (0 off, 1..3 thresholds) |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the output |
| out_data | output | DATA_W | Gated magnitude |
| noload_flag | output | 1 | Sticky no-load status |
| noload_en | input | 1 | Interrupt enable |
| noload_clr | input | 1 | Clear strobe for the flag |
| noload_irq | output | 1 | Interrupt request |

## Verification
The bench builds the gate with DATA_W=24 and FULL_SCALE=1,000,000. These values make the three thresholds the exact integers 300, 150 and 75, so the cases one below and exactly at each threshold can be written as plain numbers for both sources. Keeping DATA_W at 24 also brings the all-ones input within reach, which shows that a full-scale magnitude passes through untouched. Directed cases cover a stalled output and a clear that lands together with a suppressed sample.

// File: rtl/nl_gate_pkg.sv
package nl_gate_pkg;

  typedef enum logic [1:0] {
    THR_OFF    = 2'd0,
    THR_COARSE = 2'd1,
    THR_MID    = 2'd2,
    THR_FINE   = 2'd3
  } thr_code_e;

  localparam int unsigned NUM_CODES = 4;

  // Threshold as an integer fraction of full scale, rounded down.
  function automatic longint unsigned creep_level(input longint unsigned fs,
                                                  input int unsigned code);
    longint unsigned lvl;
    case (code)
      1:       lvl = (fs * 64'd3) / 64'd10000;
      2:       lvl = (fs * 64'd3) / 64'd20000;
      3:       lvl = (fs * 64'd3) / 64'd40000;
      default: lvl = 64'd0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/nl_thresh_table.sv
module nl_thresh_table
  import nl_gate_pkg::*;
#(
  parameter int unsigned     DATA_W     = 24,
  parameter longint unsigned FULL_SCALE = 64'd16777215
) (
  input  thr_code_e          code,
  output logic [DATA_W-1:0]  level,
  output logic               active
);

  logic [DATA_W-1:0] table_q [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lvl
    localparam longint unsigned LVL = creep_level(FULL_SCALE, g);
    assign table_q[g] = DATA_W'(LVL);
  end

  always_comb begin
    level  = table_q[code];
    active = (code != THR_OFF);
  end

endmodule

// File: rtl/nl_gate_stage.sv
module nl_gate_stage #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] mag,
  input  logic [DATA_W-1:0] level,
  input  logic              active,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              suppress_evt
);

  logic              take;
  logic              below;
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  always_comb begin
    in_ready     = !vld_q || out_ready;
    take         = in_valid && in_ready;
    below        = active && (mag < level);
    suppress_evt = take && below;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      dat_q <= below ? '0 : mag;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/nl_noload_status.sv
module nl_noload_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && en_i;

endmodule

// File: rtl/nl_creep_gate.sv
module nl_creep_gate
  import nl_gate_pkg::*;
#(
  parameter int unsigned     DATA_W     = 24,
  parameter longint unsigned FULL_SCALE = 64'd16777215
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_va,
  input  logic [DATA_W-1:0] in_irms,
  input  logic              src_irms,
  input  logic [1:0]        thr_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              noload_flag,
  input  logic              noload_en,
  input  logic              noload_clr,
  output logic              noload_irq
);

  logic [DATA_W-1:0] sel_mag;
  logic [DATA_W-1:0] level;
  logic              active;
  logic              suppress_evt;
  thr_code_e         code;

  assign code    = thr_code_e'(thr_mode);
  assign sel_mag = src_irms ? in_irms : in_va;

  nl_thresh_table #(
    .DATA_W    (DATA_W),
    .FULL_SCALE(FULL_SCALE)
  ) thr_i (
    .code  (code),
    .level (level),
    .active(active)
  );

  nl_gate_stage #(
    .DATA_W(DATA_W)
  ) stage_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .mag         (sel_mag),
    .level       (level),
    .active      (active),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .suppress_evt(suppress_evt)
  );

  nl_noload_status status_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (suppress_evt),
    .clr_i (noload_clr),
    .en_i  (noload_en),
    .flag_o(noload_flag),
    .irq_o (noload_irq)
  );

endmodule

// File: rtl/nl_creep_gate_chk.sv
module nl_creep_gate_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_va,
  input logic [DATA_W-1:0] in_irms,
  input logic              src_irms,
  input logic [1:0]        thr_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              noload_flag,
  input logic              noload_en,
  input logic              noload_clr,
  input logic              noload_irq
);

  logic              fire;
  logic [DATA_W-1:0] pick;
  assign fire = in_valid && in_ready;
  assign pick = src_irms ? in_irms : in_va;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R3
  AST_PASS_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_data == '0) || (out_data == $past(pick))); // R2
  AST_MODE_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && thr_mode == 2'd0 |=> out_data == $past(pick)); // R1
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noload_flag) |-> $past(fire && thr_mode != 2'd0)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    noload_flag && !noload_clr |=> noload_flag); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    noload_irq |-> noload_flag && noload_en); // R7

endmodule

bind nl_creep_gate nl_creep_gate_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/nl_creep_gate_tb_top.sv
`timescale 1ns/1ps
module nl_creep_gate_tb_top;

  localparam int unsigned DW = 24;
  localparam longint unsigned FS = 64'd1000000;

  typedef struct packed {
    logic          src;
    logic [1:0]    mode;
    logic [DW-1:0] va;
    logic [DW-1:0] irms;
    logic [DW-1:0] exp_data;
    logic          exp_flag;
  } vec_t;

  localparam int NV = 16;
  // Thresholds with FS=1e6: code1=300, code2=150, code3=75
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 24'd0,        24'd9,    24'd0,        1'b0},
    '{1'b0, 2'd0, 24'd1,        24'd0,    24'd1,        1'b0},
    '{1'b0, 2'd1, 24'd299,      24'd5000, 24'd0,        1'b1},
    '{1'b0, 2'd1, 24'd300,      24'd5000, 24'd300,      1'b0},
    '{1'b0, 2'd2, 24'd149,      24'd5000, 24'd0,        1'b1},
    '{1'b0, 2'd2, 24'd150,      24'd0,    24'd150,      1'b0},
    '{1'b0, 2'd3, 24'd74,       24'd5000, 24'd0,        1'b1},
    '{1'b0, 2'd3, 24'd75,       24'd0,    24'd75,       1'b0},
    '{1'b1, 2'd1, 24'd9000,     24'd299,  24'd0,        1'b1},
    '{1'b1, 2'd1, 24'd0,        24'd300,  24'd300,      1'b0},
    '{1'b1, 2'd2, 24'd9000,     24'd149,  24'd0,        1'b1},
    '{1'b1, 2'd2, 24'd0,        24'd150,  24'd150,      1'b0},
    '{1'b1, 2'd3, 24'd9000,     24'd74,   24'd0,        1'b1},
    '{1'b1, 2'd3, 24'd0,        24'd75,   24'd75,       1'b0},
    '{1'b1, 2'd0, 24'd0,        24'd1,    24'd1,        1'b0},
    '{1'b0, 2'd3, 24'd16777215, 24'd0,    24'd16777215, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_va = '0;
  logic [DW-1:0] in_irms = '0;
  logic          src_irms = 1'b0;
  logic [1:0]    thr_mode = 2'd0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          noload_flag;
  logic          noload_en = 1'b0;
  logic          noload_clr = 1'b0;
  logic          noload_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nl_creep_gate #(.DATA_W(DW), .FULL_SCALE(FS)) dut_i (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); noload_clr = 1'b1;
    @(negedge clk); noload_clr = 1'b0;
  endtask

  // Drive one sample at a negedge; returns at the negedge after acceptance.
  task automatic send(input logic s, input logic [1:0] m, input logic [DW-1:0] va,
                      input logic [DW-1:0] ir);
    @(negedge clk);
    src_irms = s; thr_mode = m; in_va = va; in_irms = ir; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_valid in reset", out_valid, 0);
    chk("R9 flag in reset", noload_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 in_ready after reset", in_ready, 1);
    chk("R9 irq after reset", noload_irq, 0);

    // Table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      clear_flag();
      send(VECS[i].src, VECS[i].mode, VECS[i].va, VECS[i].irms);
      chk($sformatf("R3 vec%0d out_valid", i), out_valid, 1);
      chk($sformatf("R1 R2 R4 vec%0d out_data", i), out_data, VECS[i].exp_data);
      chk($sformatf("R5 vec%0d flag", i), noload_flag, VECS[i].exp_flag);
    end

    // R5 sticky across a passing sample
    clear_flag();
    send(1'b0, 2'd1, 24'd10, 24'd0);
    send(1'b0, 2'd1, 24'd4000, 24'd0);
    chk("R5 pass sample data", out_data, 24'd4000);
    chk("R5 flag sticky", noload_flag, 1);

    // R7 interrupt gating
    noload_en = 1'b0;
    @(negedge clk);
    chk("R7 irq with enable off", noload_irq, 0);
    noload_en = 1'b1;
    @(negedge clk);
    chk("R7 irq with enable on", noload_irq, 1);

    // R6 clear alone
    clear_flag();
    chk("R6 clear flag", noload_flag, 0);
    chk("R7 irq after clear", noload_irq, 0);

    // R6 clear with a simultaneous suppressed sample: set wins
    send(1'b0, 2'd2, 24'd3, 24'd0);
    @(negedge clk);
    src_irms = 1'b1; thr_mode = 2'd3; in_va = 24'd0; in_irms = 24'd74;
    in_valid = 1'b1; noload_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; noload_clr = 1'b0;
    chk("R6 set wins over clear", noload_flag, 1);
    chk("R6 suppressed data", out_data, 0);
    clear_flag();
    chk("R6 clear after collision", noload_flag, 0);
    noload_en = 1'b0;

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(1'b0, 2'd0, 24'd111, 24'd0);
    chk("R8 held valid", out_valid, 1);
    chk("R8 in_ready low while stalled", in_ready, 0);
    src_irms = 1'b0; thr_mode = 2'd0; in_va = 24'd222; in_valid = 1'b1;
    @(negedge clk);
    chk("R8 data held", out_data, 24'd111);
    @(negedge clk);
    chk("R8 data still held", out_data, 24'd111);
    chk("R8 valid still held", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 waiting sample taken on drain", out_data, 24'd222);
    chk("R8 valid after drain", out_valid, 1);
    @(negedge clk);
    chk("R3 output empties", out_valid, 0);
    chk("R1 flag untouched in code 0", noload_flag, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule